// File: doc/BRIEF.md
# Serial-to-Parallel Deserializer with Bit Slip

This block turns a serial bit stream, one bit per edge of a fast bit clock, into 4-bit parallel words. A 3-bit phase counter sets the word boundary. Its low bits give a divide-by-4 clock output and its full width gives a divide-by-8 clock output. The serial source is one of two inputs. The second input is meant as a loopback path for test, so the same data path can be fed from a companion serializer. In narrow mode a new word is published every 4 bit clocks. In wide mode a new word is published every 8 bit clocks, which lets two instances share the work of an 8-bit conversion.

Word alignment is adjusted with a slip request. The request is asynchronous. Each pulse on it passes through a synchronizer and an edge detector, and then holds the phase counter for one clock. This delays the boundary by one bit, so the bit that used to land on output bit n now lands on bit n-1. A synchronous reset clears the counter, the shift register and the output word, so several instances released together stay aligned.

The output side carries a one-cycle strobe that marks each new word. The serial stream cannot be stalled, so there is no ready input and no back-pressure. A consumer must take each word within the word period, while the outputs hold steady.

Top module: `bitslip_deser`

## Requirements
- R1: Within a published word, bit 0 holds the oldest of the four bits and bit 3 the newest. The word is the last four serial bits sampled, up to and including the edge that publishes it.
- R2: When `lpbk_sel` is 0, the shift source is `din_a`. When it is 1, the source is `din_b`.
- R3: `div4_clk` is high while the counter's two low bits are 0 or 1 and low while they are 2 or 3. In narrow mode it is high in the cycle a word is published and low two cycles later.
- R4: `div8_clk` is high while the 3-bit counter is 0 to 3 and low while it is 4 to 7. In wide mode it is high in the cycle a word is published and low four cycles later.
- R5: With `mode_wide` = 0, words are published every 4 bit clocks. The first word appears 4 edges after reset is released.
- R6: With `mode_wide` = 1, words are published every 8 bit clocks.
- R7: A slip request held high for at least two bit clocks stretches exactly one word interval by one clock. Every other interval is unchanged.
- R8: A slip request held high for many clocks causes only one slip. Each further slip needs a new rising edge.
- R9: While `rst` is high, the counter is 0 and both divider clocks are high. `par_q` is 0 and `word_vld` is 0.
- R10: `word_vld` is high for exactly one cycle per published word. `par_q` changes only in a cycle where `word_vld` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_wide | input | 1 | 0: publish every 4 clocks, 1: publish every 8 clocks |
| lpbk_sel | input | 1 | Serial source select, 1 picks the loopback input |
| din_a | input | 1 | Normal serial data input |
| din_b | input | 1 | Loopback serial data input |
| slip_req | input | 1 | Asynchronous boundary slip request, one slip per rising edge |
| par_q | output | 4 | Parallel word, bit 0 oldest |
| word_vld | output | 1 | One-cycle strobe marking a new word on par_q |
| div4_clk | output | 1 | Bit clock divided by 4 |
| div8_clk | output | 1 | Bit clock divided by 8 |

## Verification
The hardest case to reach from the ports is a slip request that lands at a chosen phase, combined with a request held long enough to expose repeated slipping. The slip's only visible trace is one stretched interval between strobes. The stimulus table therefore places requests at set cycles, gives two pulses in one run, and in one row holds the request high for twenty clocks. The bench measures every interval between strobes against the base period and counts the stretched ones. Each word is also compared with the last four bits the bench sent on the selected input, so an alignment slip and a wrong data path both show up.

// File: rtl/deser_pkg.sv
package deser_pkg;
  typedef enum logic {
    UPD_NARROW = 1'b0,
    UPD_WIDE   = 1'b1
  } upd_mode_e;

  function automatic int unsigned log2_ceil(input int unsigned v);
    int unsigned r;
    r = 0;
    while ((1 << r) < v) r++;
    return r;
  endfunction
endpackage

// File: rtl/slip_sync.sv
module slip_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic pulse_o
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], async_in};
  end

  // rising edge seen at the synchronizer output
  assign pulse_o = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/phase_div.sv
module phase_div import deser_pkg::*; #(
  parameter int WORD_W = 4,
  parameter int CNT_W  = log2_ceil(WORD_W) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  upd_mode_e        mode,
  output logic [CNT_W-1:0] cnt,
  output logic             load_o,
  output logic             div_w_o,
  output logic             div_2w_o
);
  localparam int LOW_W = CNT_W - 1;
  localparam logic [LOW_W-1:0] LOW_LAST = LOW_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(2 * WORD_W - 1);

  logic last;

  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (!hold) cnt <= cnt + 1'b1;
  end

  always_comb begin
    if (mode == UPD_WIDE) last = (cnt == FULL_LAST);
    else                  last = (cnt[LOW_W-1:0] == LOW_LAST);
  end

  assign load_o   = last & ~hold;
  assign div_w_o  = ~cnt[LOW_W-1];
  assign div_2w_o = ~cnt[CNT_W-1];
endmodule

// File: rtl/shift_capture.sv
module shift_capture #(
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sdin,
  input  logic              load,
  output logic [WORD_W-1:0] q,
  output logic              vld
);
  logic [WORD_W-1:0] sr;
  logic [WORD_W-1:0] sr_next;

  // newest bit enters at the top, oldest drifts toward bit 0
  assign sr_next = {sdin, sr[WORD_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sr  <= '0;
      q   <= '0;
      vld <= 1'b0;
    end else begin
      sr  <= sr_next;
      vld <= load;
      if (load) q <= sr_next;
    end
  end
endmodule

// File: rtl/bitslip_deser.sv
module bitslip_deser import deser_pkg::*; #(
  parameter int WORD_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wide,
  input  logic              lpbk_sel,
  input  logic              din_a,
  input  logic              din_b,
  input  logic              slip_req,
  output logic [WORD_W-1:0] par_q,
  output logic              word_vld,
  output logic              div4_clk,
  output logic              div8_clk
);
  localparam int CNT_W = log2_ceil(WORD_W) + 1;

  logic             slip_pulse;
  logic             load;
  logic             sdin;
  logic [CNT_W-1:0] div_cnt;
  upd_mode_e        mode;

  assign mode = mode_wide ? UPD_WIDE : UPD_NARROW;
  assign sdin = lpbk_sel ? din_b : din_a;

  slip_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (slip_req),
    .pulse_o  (slip_pulse)
  );

  phase_div #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .hold     (slip_pulse),
    .mode     (mode),
    .cnt      (div_cnt),
    .load_o   (load),
    .div_w_o  (div4_clk),
    .div_2w_o (div8_clk)
  );

  shift_capture #(.WORD_W(WORD_W)) u_cap (
    .clk  (clk),
    .rst  (rst),
    .sdin (sdin),
    .load (load),
    .q    (par_q),
    .vld  (word_vld)
  );
endmodule

// File: rtl/bitslip_deser_chk.sv
module bitslip_deser_chk #(
  parameter int WORD_W = 4,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_wide,
  input logic [WORD_W-1:0] par_q,
  input logic              word_vld,
  input logic              div_w_clk,
  input logic              div_2w_clk,
  input logic [CNT_W-1:0]  cnt,
  input logic              slip_pulse
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (par_q == '0 && !word_vld && cnt == '0)); // R9

  AST_NARROW_PHASE: assert property (@(posedge clk) disable iff (rst)
    (word_vld && !mode_wide) |-> div_w_clk); // R3

  AST_WIDE_PHASE: assert property (@(posedge clk) disable iff (rst)
    (word_vld && mode_wide) |-> div_2w_clk); // R4

  AST_SLIP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    slip_pulse |=> $stable(cnt)); // R7

  AST_COUNT_ADV: assert property (@(posedge clk) disable iff (rst)
    !slip_pulse |=> (cnt == CNT_W'($past(cnt) + 1'b1))); // R5

  AST_SINGLE_SLIP: assert property (@(posedge clk) disable iff (rst)
    slip_pulse |=> !slip_pulse); // R8

  AST_WORD_STABLE: assert property (@(posedge clk) disable iff (rst)
    !$stable(par_q) |-> word_vld); // R10

  AST_STROBE_ONE: assert property (@(posedge clk) disable iff (rst)
    word_vld |=> !word_vld); // R10
endmodule

bind bitslip_deser bitslip_deser_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode_wide  (mode_wide),
  .par_q      (par_q),
  .word_vld   (word_vld),
  .div_w_clk  (div4_clk),
  .div_2w_clk (div8_clk),
  .cnt        (div_cnt),
  .slip_pulse (slip_pulse)
);

// File: tb/test_bitslip_deser.sv
module test_bitslip_deser;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_wide = 1'b0, lpbk_sel = 1'b0;
  logic       din_a = 1'b0, din_b = 1'b0, slip_req = 1'b0;
  logic [3:0] par_q;
  logic       word_vld, div4_clk, div8_clk;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  bitslip_deser i_bitslip_deser (
    .clk(clk), .rst(rst), .mode_wide(mode_wide), .lpbk_sel(lpbk_sel),
    .din_a(din_a), .din_b(din_b), .slip_req(slip_req),
    .par_q(par_q), .word_vld(word_vld), .div4_clk(div4_clk), .div8_clk(div8_clk)
  );

  typedef struct packed {
    logic        mode;
    logic        sel;
    logic [31:0] pat_a;
    logic [31:0] pat_b;
    logic [7:0]  s1;
    logic [7:0]  s2;
    logic [7:0]  len;
    logic [7:0]  exp_ext;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 32'hB4C3_92E1, 32'h0F0F_0F0F, 8'hFF, 8'hFF, 8'd0,  8'd0},
    '{1'b0, 1'b1, 32'h1234_5678, 32'hD2A7_6C19, 8'hFF, 8'hFF, 8'd0,  8'd0},
    '{1'b1, 1'b0, 32'h8E31_F05A, 32'h0000_0000, 8'hFF, 8'hFF, 8'd0,  8'd0},
    '{1'b0, 1'b0, 32'h9A5C_3E71, 32'hFFFF_FFFF, 8'd10, 8'hFF, 8'd2,  8'd1},
    '{1'b1, 1'b1, 32'h5555_5555, 32'h6B1E_C48D, 8'd10, 8'd34, 8'd2,  8'd2},
    '{1'b0, 1'b0, 32'hC71B_0E9D, 32'h0000_0000, 8'd6,  8'hFF, 8'd20, 8'd1},
    '{1'b0, 1'b1, 32'h0000_0000, 32'hE38F_1A6B, 8'd5,  8'd30, 8'd3,  8'd2}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    slip_req = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state at the ports
    check(par_q == 4'h0, "R9 par_q", par_q, 0);
    check(word_vld == 1'b0, "R9 word_vld", word_vld, 0);
    check(div4_clk == 1'b1, "R9 div4_clk", div4_clk, 1);
    check(div8_clk == 1'b1, "R9 div8_clk", div8_clk, 1);
  endtask

  task automatic run_vec(input vec_t v);
    int period, last, ext, nvld;
    logic [7:0] hist;
    logic bit_a, bit_b;
    period = v.mode ? 8 : 4;
    last = 0; ext = 0; nvld = 0; hist = '0;
    mode_wide = v.mode;
    lpbk_sel  = v.sel;
    do_reset();
    rst = 1'b0;
    for (int i = 0; i < 64; i++) begin
      // outputs here reflect i edges since reset release
      if (word_vld) begin
        nvld++;
        check(par_q == hist[7:4], "R1/R2 word", par_q, hist[7:4]);
        if (i - last == period + 1) ext++;
        else check(i - last == period, v.mode ? "R6 interval" : "R5 interval", i - last, period);
        if (v.mode) check(div8_clk == 1'b1, "R4 div8 at word", div8_clk, 1);
        else        check(div4_clk == 1'b1, "R3 div4 at word", div4_clk, 1);
        last = i;
      end
      if (v.s1 == 8'hFF && i == last + 2 && !v.mode)
        check(div4_clk == 1'b0, "R3 div4 low phase", div4_clk, 0);
      if (v.s1 == 8'hFF && i == last + 4 && v.mode)
        check(div8_clk == 1'b0, "R4 div8 low phase", div8_clk, 0);
      bit_a = v.pat_a[i % 32];
      bit_b = v.pat_b[i % 32];
      din_a = bit_a;
      din_b = bit_b;
      hist  = {(v.sel ? bit_b : bit_a), hist[7:1]};
      slip_req = ((i >= int'(v.s1)) && (i < int'(v.s1) + int'(v.len))) ||
                 ((i >= int'(v.s2)) && (i < int'(v.s2) + int'(v.len)));
      @(negedge clk);
    end
    slip_req = 1'b0;
    check(ext == int'(v.exp_ext), "R7/R8 slip count", ext, v.exp_ext);
    check(nvld >= 64 / (period + 1) - 1, "R10 strobe count", nvld, 64 / (period + 1) - 1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    @(negedge clk);
    for (int k = 0; k < NV; k++) run_vec(VECS[k]);
    // directed: reset in the middle of a word clears a nonzero output (R9)
    mode_wide = 1'b0; lpbk_sel = 1'b0;
    rst = 1'b0;
    for (int i = 0; i < 6; i++) begin
      din_a = 1'b1;
      @(negedge clk);
    end
    check(par_q == 4'hF, "R1 all ones word", par_q, 4'hF);
    do_reset();
    // directed: a single-cycle reset pulse also realigns the counter (R5)
    rst = 1'b0;
    din_a = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(word_vld == 1'b0, "R5 no early word", word_vld, 0);
    @(negedge clk);
    check(word_vld == 1'b1, "R5 first word at 4", word_vld, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule